// File: doc/BRIEF.md
# DSI Peripheral Read Response Parser

After a bus turnaround, a display serial interface host finds the peripheral's reply in a receive FIFO as 32-bit words. This block takes those words over a valid/ready stream and decodes them. The first word is the packet header. Its low six bits select the kind of response. An acknowledge-with-error report is turned into a 16-bit error vector. A short read reply yields one or two bytes taken straight from the header. A long read reply gives a 16-bit byte count, and its payload bytes are unpacked from the following words.

Software, or a sequencer, starts a transaction with a one-cycle `start_i`. With it come the number of words the FIFO holds, which includes the header, and the largest number of bytes the caller will accept. The block then accepts exactly that many words and sends the accepted bytes out one per cycle, lowest byte lane first. It ends with a one-cycle `done_i`-style pulse on `done_o`, and at that pulse the status, byte count and error vector are valid. Any words left over are still consumed, so the FIFO is empty afterwards whatever the outcome.

The block does not check ECC or checksums.

Top module: `dsi_rsp_parser`

## Requirements
- R1: The response type is bits 5:0 of the first word; bits 7:6 are ignored. The recognised codes are 0x02 (acknowledge with error report), 0x21 (one-byte short read), 0x22 (two-byte short read), 0x1A (generic long read) and 0x1C (command-set long read). Any other code ends with status 2 (protocol error), no bytes and a byte count of 0.
- R2: For code 0x02, `err_vec_o` equals bits 23:8 of the header, with error bit i at position i. The bit order from 0 to 15 is: start-of-transmission error, start sync, end sync, escape entry, low-power sync, peripheral timeout, false control, contention, single-bit ECC, multi-bit ECC, checksum, unknown data type, bad virtual channel, bad length, reserved, protocol violation. Status is 1 and no bytes are sent. For any other status `err_vec_o` is 0.
- R3: Code 0x21 sends header bits 15:8. Code 0x22 sends bits 15:8 and then bits 23:16. Status is 0 for both.
- R4: For codes 0x1A and 0x1C the decoded size is header bits 23:8, so header byte 1 is the low byte of the size. Status is 0.
- R5: `byte_count_o` is the smaller of the decoded size and the latched `max_len_i`. No more bytes than that are sent.
- R6: Long payload words are unpacked least significant byte first, bits 7:0 up to bits 31:24. Payload bytes past the limit are dropped. If the payload words run out first, fewer bytes are sent.
- R7: Exactly `word_count_i` words are accepted per transaction, header included. Words left after an error or after truncation are drained. `in_ready_o` is 0 when `done_o` is high.
- R8: A transaction with `word_count_i` = 0 accepts no words and ends with status 3, a byte count of 0 and no bytes.
- R9: `done_o` is a one-cycle pulse that comes after the transaction's last byte pulse and never in the same cycle as a byte. A `start_i` that arrives during a transaction is ignored.
- R10: After reset, `in_ready_o`, `byte_valid_o`, `done_o`, `status_o`, `byte_count_o` and `err_vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction (honoured only when idle) |
| word_count_i | input | CNT_W | Receive FIFO word count, header included |
| max_len_i | input | LEN_W | Largest byte count the caller accepts |
| in_valid_i | input | 1 | Receive word valid |
| in_data_i | input | DATA_W | Receive word |
| in_ready_o | output | 1 | Block takes the word this cycle |
| byte_valid_o | output | 1 | Output byte valid |
| byte_data_o | output | 8 | Output byte |
| byte_count_o | output | LEN_W | Delivered count, min(size, max length) |
| err_vec_o | output | 16 | Error report vector |
| status_o | output | 2 | 0 ok, 1 error report, 2 protocol error, 3 empty |
| done_o | output | 1 | Transaction complete pulse |

## Verification
Two things can land on the same edge: the last byte the length limit allows, and the end of a payload word while more words are still waiting in the FIFO. When that happens the parser must stop sending bytes at that edge and move to draining at the next one. The bench makes this happen by sweeping every long-read size and limit from 0 to 9, which puts the cut-off on every byte lane both with and without trailing words. It then compares the collected bytes, the count of accepted words and the returned count against a model worked out arithmetically. A `start_i` pulse sent in the middle of a transfer, and gaps in `in_valid_i`, are added on top of the same runs.

// File: rtl/dsi_rsp_pkg.sv
package dsi_rsp_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_ACK_ERR = 2'd1,
    ST_PROTO   = 2'd2,
    ST_EMPTY   = 2'd3
  } rsp_status_e;

  typedef enum logic [2:0] {
    K_ACK,
    K_SHORT1,
    K_SHORT2,
    K_LONG,
    K_BAD
  } rsp_kind_e;

  localparam logic [5:0] DT_ACK_ERR  = 6'h02;
  localparam logic [5:0] DT_SHORT1   = 6'h21;
  localparam logic [5:0] DT_SHORT2   = 6'h22;
  localparam logic [5:0] DT_GEN_LONG = 6'h1A;
  localparam logic [5:0] DT_DCS_LONG = 6'h1C;
  localparam int         ERR_W       = 16;
endpackage

// File: rtl/dsi_rsp_hdr_decode.sv
module dsi_rsp_hdr_decode
  import dsi_rsp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [23:0]      hdr_i,
  input  logic [LEN_W-1:0] max_len_i,
  output rsp_kind_e        kind_o,
  output logic [LEN_W-1:0] lim_o,
  output logic [ERR_W-1:0] err_o
);
  logic [LEN_W-1:0] size;

  always_comb begin
    kind_o = K_BAD;
    size   = '0;
    err_o  = '0;
    case (hdr_i[5:0])
      DT_ACK_ERR: begin
        kind_o = K_ACK;
        err_o  = hdr_i[23:8];
      end
      DT_SHORT1: begin
        kind_o = K_SHORT1;
        size   = LEN_W'(1);
      end
      DT_SHORT2: begin
        kind_o = K_SHORT2;
        size   = LEN_W'(2);
      end
      DT_GEN_LONG, DT_DCS_LONG: begin
        kind_o = K_LONG;
        size   = LEN_W'(hdr_i[23:8]);
      end
      default: kind_o = K_BAD;
    endcase
    lim_o = (size < max_len_i) ? size : max_len_i;
  end
endmodule

// File: rtl/dsi_rsp_unpack.sv
module dsi_rsp_unpack #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_len_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              step_i,
  output logic [LEN_W-1:0]  left_o,
  output logic              word_end_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][7:0] buf_q;
  logic [LANE_W-1:0]     lane_q;
  logic [LEN_W-1:0]      left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q        <= '0;
      lane_q       <= '0;
      left_q       <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (set_len_i) left_q <= len_i;
      if (load_i) begin
        buf_q  <= word_i;
        lane_q <= '0;
      end
      if (step_i) begin
        byte_valid_o <= 1'b1;
        byte_o       <= buf_q[lane_q];
        lane_q       <= lane_q + LANE_W'(1);
        left_q       <= left_q - LEN_W'(1);
      end
    end
  end

  assign left_o     = left_q;
  assign word_end_o = (left_q == LEN_W'(1)) || (lane_q == LANE_W'(LANES - 1));

  AST_STEP_HAS_BYTES: assert property (@(posedge clk) disable iff (rst)
    step_i |-> left_q != '0);  // R5
endmodule

// File: rtl/dsi_rsp_parser.sv
module dsi_rsp_parser
  import dsi_rsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  word_count_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  output logic [LEN_W-1:0]  byte_count_o,
  output logic [15:0]       err_vec_o,
  output logic [1:0]        status_o,
  output logic              done_o
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_FETCH, S_EMIT, S_FIN} state_e;

  state_e            state;
  logic [CNT_W-1:0]  words_left;
  logic [LEN_W-1:0]  max_len_q;
  logic              fire, last_word, is_short;
  rsp_kind_e         kind;
  logic [LEN_W-1:0]  lim;
  logic [ERR_W-1:0]  hdr_err;
  logic [LEN_W-1:0]  bytes_left;
  logic              word_end;
  logic              set_len, load_word, step;
  logic [DATA_W-1:0] word_in;

  dsi_rsp_hdr_decode #(.LEN_W(LEN_W)) u_dec (
    .hdr_i     (in_data_i[23:0]),
    .max_len_i (max_len_q),
    .kind_o    (kind),
    .lim_o     (lim),
    .err_o     (hdr_err)
  );

  assign in_ready_o = (state == S_HDR) || (state == S_FETCH);
  assign fire       = in_valid_i && in_ready_o;
  assign last_word  = (words_left == CNT_W'(1));
  assign is_short   = (kind == K_SHORT1) || (kind == K_SHORT2);

  assign set_len   = (state == S_HDR) && fire;
  assign load_word = ((state == S_HDR) && fire && is_short) ||
                     ((state == S_FETCH) && fire && (bytes_left != '0));
  assign word_in   = (state == S_HDR) ? {8'h00, in_data_i[DATA_W-1:8]} : in_data_i;
  assign step      = (state == S_EMIT);

  dsi_rsp_unpack #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_unpack (
    .clk          (clk),
    .rst          (rst),
    .set_len_i    (set_len),
    .len_i        (lim),
    .load_i       (load_word),
    .word_i       (word_in),
    .step_i       (step),
    .left_o       (bytes_left),
    .word_end_o   (word_end),
    .byte_valid_o (byte_valid_o),
    .byte_o       (byte_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      words_left   <= '0;
      max_len_q    <= '0;
      byte_count_o <= '0;
      err_vec_o    <= '0;
      status_o     <= ST_OK;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          max_len_q    <= max_len_i;
          words_left   <= word_count_i;
          byte_count_o <= '0;
          err_vec_o    <= '0;
          if (word_count_i == '0) begin
            status_o <= ST_EMPTY;
            state    <= S_FIN;
          end else begin
            status_o <= ST_OK;
            state    <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          words_left   <= words_left - CNT_W'(1);
          byte_count_o <= lim;
          err_vec_o    <= hdr_err;
          case (kind)
            K_ACK:   status_o <= ST_ACK_ERR;
            K_BAD:   status_o <= ST_PROTO;
            default: status_o <= ST_OK;
          endcase
          if (is_short && (lim != '0)) state <= S_EMIT;
          else                         state <= last_word ? S_FIN : S_FETCH;
        end
        S_FETCH: if (fire) begin
          words_left <= words_left - CNT_W'(1);
          if (bytes_left != '0) state <= S_EMIT;
          else if (last_word)   state <= S_FIN;
        end
        S_EMIT: if (word_end) state <= (words_left == '0) ? S_FIN : S_FETCH;
        S_FIN: begin
          done_o <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R9
  AST_DONE_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !byte_valid_o);  // R9
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (words_left == '0) && !in_ready_o);  // R7
  AST_PROTO_NO_BYTES: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == ST_PROTO) |-> byte_count_o == '0);  // R1
  AST_ERR_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o != ST_ACK_ERR) |-> err_vec_o == '0);  // R2
  AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == S_HDR && fire) |-> lim <= max_len_q);  // R5
endmodule

// File: tb/dsi_rsp_parser_test.sv
module dsi_rsp_parser_test;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 5;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  word_count = '0;
  logic [LEN_W-1:0]  max_len = '0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ready, byte_valid, done;
  logic [7:0]        byte_data;
  logic [LEN_W-1:0]  byte_count;
  logic [15:0]       err_vec;
  logic [1:0]        status;

  int errors = 0;
  int checks = 0;
  int nacc = 0;
  logic [7:0] got[$];
  logic [31:0] wq [0:15];

  always #4 clk = ~clk;

  dsi_rsp_parser #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .start_i(start), .word_count_i(word_count),
    .max_len_i(max_len), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .byte_valid_o(byte_valid), .byte_data_o(byte_data),
    .byte_count_o(byte_count), .err_vec_o(err_vec), .status_o(status), .done_o(done)
  );

  always @(negedge clk) begin
    if (byte_valid) got.push_back(byte_data);
    if (in_valid && in_ready) nacc++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int wc, input int maxl, input bit poke, input string req);
    logic [7:0]  eb [0:63];
    logic [5:0]  dt;
    int          size, lim, en, expst, guard;
    logic [15:0] experr;
    size = 0; en = 0; expst = 0; experr = '0;
    dt = wq[0][5:0];
    if (wc == 0) expst = 3;
    else begin
      case (dt)
        6'h02: begin expst = 1; experr = wq[0][23:8]; end
        6'h21: begin size = 1; eb[0] = wq[0][15:8]; end
        6'h22: begin size = 2; eb[0] = wq[0][15:8]; eb[1] = wq[0][23:16]; end
        6'h1A, 6'h1C: size = int'(wq[0][23:8]);
        default: expst = 2;
      endcase
    end
    lim = (size < maxl) ? size : maxl;
    en  = lim;
    if (wc > 0 && (dt == 6'h1A || dt == 6'h1C)) begin
      if (en > 4 * (wc - 1)) en = 4 * (wc - 1);
      for (int i = 0; i < en; i++) eb[i] = wq[1 + i / 4][8 * (i % 4) +: 8];
    end
    @(negedge clk);
    got.delete();
    nacc = 0;
    start = 1'b1; word_count = CNT_W'(wc); max_len = LEN_W'(maxl);
    @(negedge clk);
    start = 1'b0; word_count = CNT_W'(1); max_len = LEN_W'(1);
    for (int k = 0; k < wc; k++) begin
      if ((k + wc) % 3 == 2) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_data = wq[k];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      start = poke && (k == 0);
    end
    in_valid = 1'b0; in_data = '0; start = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    check(done, req, "done seen", done, 1);
    check(status == 2'(expst), req, "status", status, expst);
    check(byte_count == LEN_W'(lim), req, "byte count", byte_count, lim);
    check(err_vec == experr, req, "error vector", err_vec, experr);
    check(nacc == wc, "R7", "words accepted", nacc, wc);
    check(!in_ready, "R7", "ready low at done", in_ready, 0);
    check(got.size() == en, req, "bytes delivered", got.size(), en);
    if (got.size() == en)
      for (int i = 0; i < en; i++) check(got[i] == eb[i], req, "byte value", got[i], eb[i]);
    @(negedge clk);
    check(!done, "R9", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(!in_ready && !byte_valid && !done, "R10", "handshake outputs", {in_ready, byte_valid, done}, 0);
    check(status == 0 && byte_count == 0 && err_vec == 0, "R10", "result outputs",
          {status, byte_count, err_vec}, 0);

    // R8 empty transaction
    wq[0] = 32'h0;
    run(0, 4, 1'b0, "R8");

    // R2 error report, each bit alone, type bits 7:6 set (R1)
    for (int b = 0; b < 16; b++) begin
      wq[0] = {8'h5A, 16'(1 << b), 8'hC2};
      run(1, 5, 1'b0, "R2");
    end
    wq[0] = {8'h00, 16'hFFFF, 8'h02}; wq[1] = 32'h1234_5678; wq[2] = 32'h9ABC_DEF0;
    run(3, 8, 1'b0, "R2");

    // R3 short reads with limits 0..3, with and without trailing words
    for (int m = 0; m < 4; m++) begin
      wq[0] = {8'h00, 8'hB7, 8'h3C, 8'h21}; wq[1] = 32'hDEAD_BEEF;
      run(1 + (m % 2), m, 1'b0, "R3");
      wq[0] = {8'h00, 8'hB7, 8'h3C, 8'h62};
      run(1 + (m % 2), m, 1'b0, "R3");
    end

    // R4 R5 R6 long reads: every size/limit pairing 0..9
    for (int s = 0; s < 10; s++) begin
      for (int m = 0; m < 10; m++) begin
        int nw;
        nw = 1 + (s + 3) / 4;
        wq[0] = {8'h00, 16'(s), ((s + m) % 2 == 0) ? 8'h1A : 8'h1C};
        for (int j = 1; j < nw; j++)
          for (int i = 0; i < 4; i++) wq[j][8 * i +: 8] = 8'(16 * j + i + 7 * s + m);
        run(nw, m, (nw >= 3) && (m % 3 == 0), (m < s) ? "R5" : "R6");
      end
    end

    // R4 size high byte from header byte 2; payload runs out first
    wq[0] = {8'h00, 8'h01, 8'h02, 8'h1C}; wq[1] = 32'h4433_2211;
    run(2, 300, 1'b0, "R4");

    // R1 every unrecognised type, with a trailing word to drain
    for (int t = 0; t < 64; t++) begin
      if (t == 'h02 || t == 'h21 || t == 'h22 || t == 'h1A || t == 'h1C) continue;
      wq[0] = {8'h00, 8'h05, 8'h05, 2'b00, 6'(t)}; wq[1] = 32'hCAFE_F00D;
      run(2, 9, 1'b0, "R1");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule